// File: doc/BRIEF.md
# I2C Serial EEPROM Target Engine

This block is the bus-facing engine of a byte-wide serial memory with a 16-bit word address. It oversamples the two bus wires on the system clock, finds START, repeated START and STOP, and compares the device word against a fixed `1010` prefix and three chip-select pins. It acknowledges by pulling SDA low through an open-drain output enable. It loads a two-byte word address, keeps a persistent address counter, strobes written bytes to the array and shifts stored bytes out for current-address, sequential and random reads.

A write-cycle controller outside the block receives each written byte on a one-cycle strobe and a one-cycle strobe when the write is ended by STOP. While it reports busy, the engine ignores every command. The memory array sits outside the block and returns read data one system clock after the address is presented.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A device word is accepted only when its bits [7:4] are `1010` and bits [3:1] equal `cs_i`. On any other word no acknowledge is given and every later byte is ignored (never acknowledged) until the next START.
- R2: An acknowledge is `sda_oe_o` high from the 8th SCL falling edge of a received byte until the 9th SCL falling edge, so that SDA reads low while SCL is high on the 9th clock.
- R3: After a device word with bit 0 = 0, the next two bytes are the word address, high byte first; each is acknowledged and the pair loads the address counter.
- R4: Each further byte of a write is acknowledged and presented as a one-cycle `mem_we_o` pulse with `mem_wdata_o` at `mem_addr_o`; then only the low 7 address bits increment, wrapping inside the 128-byte page.
- R5: STOP after at least one data byte pulses `stop_o` for one cycle. A START before STOP abandons the write command, and a later STOP gives no `stop_o` pulse.
- R6: After a device word with bit 0 = 1, the byte at the address counter is sent MSB first, and the counter then increments by one; a read with no address transfer continues at the last accessed address plus one.
- R7: A master acknowledge (SDA low on the 9th clock of a read byte) requests the next byte; a missing acknowledge ends the read, the block releases SDA and waits for START.
- R8: In a read, the counter wraps from 0xFFFF to 0x0000.
- R9: While `busy_i` is high, a matching device word is not acknowledged.
- R10: During and after reset, `sda_oe_o`, `mem_we_o` and `stop_o` are low.
- R11: `sda_oe_o` changes only while the synchronized SCL is low, except on START or STOP.

Top module ports are listed in declaration order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line, as seen on the wire |
| cs_i | input | 3 | Chip-select pin states |
| busy_i | input | 1 | Self-timed write in progress |
| mem_rdata_i | input | 8 | Array data for `mem_addr_o`, one cycle late |
| sda_oe_o | output | 1 | Pull SDA low when high |
| mem_addr_o | output | 16 | Address counter |
| mem_wdata_o | output | 8 | Byte to write |
| mem_we_o | output | 1 | One-cycle write-byte strobe |
| stop_o | output | 1 | One-cycle end-of-write strobe |

## Verification
A wrong address counter shows up on the first byte of the next read, or on the address carried by the next write strobe, within one byte time. A wrong command phase shows at the ports within one SCL period, as a missing or extra acknowledge on the following byte, or as a write strobe where an address byte was due. A wrong busy or abandoned-write decision shows on the next device word or STOP. So each test ends with a read or a strobe check, and the bench probes wraps and repeated STARTs at those points.

// File: rtl/i2c_eep_pkg.sv
package i2c_eep_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RXACK, ST_TX, ST_TXACK} state_e;
  typedef enum logic [1:0] {PH_DEV, PH_AHI, PH_ALO, PH_DATA} phase_e;
  localparam logic [3:0] DEV_PREFIX = 4'b1010;
endpackage

// File: rtl/i2c_eep_bus_sync.sv
module i2c_eep_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_o;
      sda_p <= sda_o;
    end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/i2c_eep_addr_ctr.sv
module i2c_eep_addr_ctr #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  input  logic              page_inc_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (inc_i)       cnt_q <= cnt_q + 1'b1;
    else if (page_inc_i)  cnt_q <= {cnt_q[ADDR_W-1:PAGE_W], cnt_q[PAGE_W-1:0] + 1'b1};

  assign addr_o = cnt_q;
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2c_eep_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PAGE_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        cs_i,
  input  logic              busy_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_we_o,
  output logic              stop_o
);
  localparam int HI_W = ADDR_W - 8;

  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  state_e st_q;
  phase_e ph_q;
  logic [3:0] cnt_q;
  logic [7:0] rx_q;
  logic [6:0] tx_q;
  logic [HI_W-1:0] ahi_q;
  logic rd_q, mack_q, wr_pend_q, oe_q, we_q, stop_q;
  logic [7:0] wdata_q;
  logic byte_done, ack_done, tx_load, ctr_load, ctr_page;

  i2c_eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(bus_start), .stop_o(bus_stop)
  );

  assign byte_done = !bus_start && !bus_stop && st_q == ST_RX && scl_fall && cnt_q == 4'd8;
  assign ack_done  = !bus_start && !bus_stop && st_q == ST_RXACK && scl_fall;
  assign ctr_load  = byte_done && ph_q == PH_ALO;
  assign ctr_page  = ack_done && ph_q == PH_DATA;
  assign tx_load   = (ack_done && ph_q == PH_DEV && rd_q) ||
                     (!bus_start && !bus_stop && st_q == ST_TXACK && scl_fall && mack_q);

  i2c_eep_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk_i, .rst_ni,
    .load_i(ctr_load), .load_val_i({ahi_q, rx_q}),
    .inc_i(tx_load), .page_inc_i(ctr_page),
    .addr_o(mem_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q <= ST_IDLE;  ph_q <= PH_DEV;  cnt_q <= '0;
      rx_q <= '0;  tx_q <= '0;  ahi_q <= '0;
      rd_q <= 1'b0;  mack_q <= 1'b0;  wr_pend_q <= 1'b0;
      oe_q <= 1'b0;  we_q <= 1'b0;  stop_q <= 1'b0;  wdata_q <= '0;
    end else begin
      we_q   <= 1'b0;
      stop_q <= 1'b0;
      if (bus_start) begin
        st_q <= ST_RX;  ph_q <= PH_DEV;  cnt_q <= '0;
        oe_q <= 1'b0;   wr_pend_q <= 1'b0;
      end else if (bus_stop) begin
        st_q <= ST_IDLE;  oe_q <= 1'b0;
        stop_q <= wr_pend_q;  wr_pend_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_RX: begin
            if (scl_rise) begin
              rx_q  <= {rx_q[6:0], sda_s};
              cnt_q <= cnt_q + 1'b1;
            end else if (byte_done) begin
              st_q <= ST_RXACK;
              oe_q <= 1'b1;
              unique case (ph_q)
                PH_DEV: begin
                  rd_q <= rx_q[0];
                  if (rx_q[7:1] != {DEV_PREFIX, cs_i} || busy_i) begin
                    st_q <= ST_IDLE;
                    oe_q <= 1'b0;
                  end
                end
                PH_AHI: ahi_q <= rx_q[HI_W-1:0];
                PH_ALO: ;
                PH_DATA: begin
                  we_q      <= 1'b1;
                  wdata_q   <= rx_q;
                  wr_pend_q <= 1'b1;
                end
                default: ;
              endcase
            end
          end
          ST_RXACK: if (scl_fall) begin
            cnt_q <= '0;
            if (ph_q == PH_DEV && rd_q) begin
              st_q <= ST_TX;
              tx_q <= mem_rdata_i[6:0];
              oe_q <= ~mem_rdata_i[7];
            end else begin
              st_q <= ST_RX;
              oe_q <= 1'b0;
              ph_q <= (ph_q == PH_DEV) ? PH_AHI :
                      (ph_q == PH_AHI) ? PH_ALO : PH_DATA;
            end
          end
          ST_TX: if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              st_q <= ST_TXACK;
              oe_q <= 1'b0;   // release for master acknowledge
            end else begin
              oe_q  <= ~tx_q[6];
              tx_q  <= {tx_q[5:0], 1'b0};
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_TXACK: begin
            if (scl_rise) mack_q <= ~sda_s;
            else if (scl_fall) begin
              cnt_q <= '0;
              if (mack_q) begin
                st_q <= ST_TX;
                tx_q <= mem_rdata_i[6:0];
                oe_q <= ~mem_rdata_i[7];
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end

  assign sda_oe_o    = oe_q;
  assign mem_we_o    = we_q;
  assign mem_wdata_o = wdata_q;
  assign stop_o      = stop_q;
endmodule

// File: rtl/i2c_eep_checker.sv
module i2c_eep_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s_i,
  input logic              sda_oe_i,
  input logic              mem_we_i,
  input logic              stop_i,
  input logic              busy_i,
  input logic              dev_ack_i,
  input logic              in_tx_i,
  input logic [ADDR_W-1:0] mem_addr_i
);
  assert_oe_scl_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s_i && $past(scl_s_i)) |-> $stable(sda_oe_i));

  assert_we_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> !mem_we_i);

  assert_stop_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !stop_i);

  assert_stop_not_with_we_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stop_i && mem_we_i));

  assert_no_ack_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_oe_i) && dev_ack_i) |-> !$past(busy_i));

  assert_read_advance_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_tx_i) |-> mem_addr_i == ADDR_W'($past(mem_addr_i) + 1'b1));
endmodule

bind i2c_eeprom_target i2c_eep_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_oe_i(sda_oe_o),
  .mem_we_i(mem_we_o), .stop_i(stop_o), .busy_i(busy_i),
  .dev_ack_i(st_q == ST_RXACK && ph_q == PH_DEV),
  .in_tx_i(st_q == ST_TX), .mem_addr_i(mem_addr_o)
);

// File: tb/i2c_eeprom_target_tb.sv
module i2c_eeprom_target_tb;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_sda = 1'b1, busy = 1'b0;
  logic [2:0] cs = 3'b101;
  logic [7:0] rdata, wdata;
  logic [15:0] addr;
  logic sda_oe, we, stp, sda_line;
  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  logic [15:0] wlog_a [8];
  logic [7:0]  wlog_d [8];
  int n_we = 0, n_stop = 0, vecs = 0, errs = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign sda_line = sda_oe ? 1'b0 : m_sda;

  i2c_eeprom_target u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .cs_i(cs),
    .busy_i(busy), .mem_rdata_i(rdata), .sda_oe_o(sda_oe), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .mem_we_o(we), .stop_o(stp)
  );

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 37 + 11) & 8'hFF);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
    end else if (we) begin
      mem[addr[7:0]] <= wdata;
    end
    rdata <= mem[addr[7:0]];
  end

  always @(posedge clk) if (rst_n) begin
    if (we) begin
      wlog_a[n_we % 8] <= addr;
      wlog_d[n_we % 8] <= wdata;
      n_we <= n_we + 1;
    end
    if (stp) n_stop <= n_stop + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    if (!scl) begin
      m_sda = 1'b1; wq(); scl = 1'b1; wq();
    end
    m_sda = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wq(); scl = 1'b1; wq(); m_sda = 1'b1; wq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(); scl = 1'b1; wq(2); scl = 1'b0; wq();
    end
    m_sda = 1'b1; wq(); scl = 1'b1; wq();
    ack = (sda_line == 1'b0);
    wq(); scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1'b1; wq(); b[i] = sda_line; wq(); scl = 1'b0; wq();
    end
    m_sda = mack ? 1'b0 : 1'b1; wq(); scl = 1'b1; wq(2); scl = 1'b0; wq();
    m_sda = 1'b1;
  endtask

  function automatic logic [7:0] dev_w();
    return {4'b1010, cs, 1'b0};
  endfunction
  function automatic logic [7:0] dev_r();
    return {4'b1010, cs, 1'b1};
  endfunction

  task automatic set_addr(input logic [15:0] a);
    bit k;
    i2c_start();
    send_byte(dev_w(), k);       chk(k, "R2 dev ack", k, 1);
    send_byte(a[15:8], k);       chk(k, "R3 addr hi ack", k, 1);
    send_byte(a[7:0], k);        chk(k, "R3 addr lo ack", k, 1);
  endtask

  task automatic t_reset();
    chk(sda_oe == 0 && we == 0 && stp == 0, "R10 reset outputs", {sda_oe, we, stp}, 0);
  endtask

  task automatic t_mismatch();
    bit k;
    i2c_start();
    send_byte({4'b1010, 3'b010, 1'b0}, k); chk(!k, "R1 cs mismatch nack", k, 0);
    send_byte(8'h12, k);                   chk(!k, "R1 ignored after mismatch", k, 0);
    i2c_stop();
    i2c_start();
    send_byte({4'b1011, cs, 1'b0}, k);     chk(!k, "R1 prefix mismatch nack", k, 0);
    i2c_stop();
    chk(n_we == 0 && n_stop == 0, "R1 no strobes", n_we + n_stop, 0);
  endtask

  task automatic t_byte_write();
    bit k;
    int s0 = n_stop, w0 = n_we;
    set_addr(16'h1234);
    send_byte(8'h5A, k); chk(k, "R4 data ack", k, 1);
    i2c_stop();
    ref_mem[8'h34] = 8'h5A;
    wq();
    chk(n_we == w0 + 1, "R4 one write strobe", n_we - w0, 1);
    chk(wlog_a[w0 % 8] == 16'h1234, "R4 write addr", wlog_a[w0 % 8], 16'h1234);
    chk(wlog_d[w0 % 8] == 8'h5A, "R4 write data", wlog_d[w0 % 8], 8'h5A);
    chk(n_stop == s0 + 1, "R5 stop strobe", n_stop - s0, 1);
  endtask

  task automatic t_cur_read();
    bit k;
    logic [7:0] b;
    for (int j = 0; j < 2; j++) begin
      i2c_start();
      send_byte(dev_r(), k); chk(k, "R6 read dev ack", k, 1);
      recv_byte(1'b0, b);
      i2c_stop();
      chk(b == ref_mem[8'h35 + j], "R6 current address read", b, ref_mem[8'h35 + j]);
    end
  endtask

  task automatic t_page_wrap();
    bit k;
    int w0 = n_we, s0 = n_stop;
    logic [7:0] d [3] = '{8'h11, 8'h22, 8'h33};
    logic [15:0] ea [3] = '{16'h12FE, 16'h12FF, 16'h1280};
    set_addr(16'h12FE);
    for (int j = 0; j < 3; j++) begin
      send_byte(d[j], k); chk(k, "R4 page data ack", k, 1);
      ref_mem[ea[j][7:0]] = d[j];
    end
    i2c_stop();
    wq();
    for (int j = 0; j < 3; j++)
      chk(wlog_a[(w0 + j) % 8] == ea[j], "R4 page wrap addr", wlog_a[(w0 + j) % 8], ea[j]);
    chk(n_stop == s0 + 1, "R5 page stop strobe", n_stop - s0, 1);
  endtask

  task automatic t_random_read();
    bit k;
    logic [7:0] b;
    int w0 = n_we, s0 = n_stop;
    set_addr(16'h0040);
    i2c_start();
    send_byte(dev_r(), k); chk(k, "R6 random read ack", k, 1);
    recv_byte(1'b0, b);
    i2c_stop();
    wq();
    chk(b == ref_mem[8'h40], "R6 random read data", b, ref_mem[8'h40]);
    chk(n_we == w0 && n_stop == s0, "R5 abandoned write no strobe", (n_we - w0) + (n_stop - s0), 0);
  endtask

  task automatic t_seq_wrap();
    bit k;
    logic [7:0] b;
    set_addr(16'hFFFE);
    i2c_start();
    send_byte(dev_r(), k);
    recv_byte(1'b1, b); chk(b == ref_mem[8'hFE], "R7 seq byte 0", b, ref_mem[8'hFE]);
    recv_byte(1'b1, b); chk(b == ref_mem[8'hFF], "R7 seq byte 1", b, ref_mem[8'hFF]);
    recv_byte(1'b0, b); chk(b == ref_mem[8'h00], "R8 wrap to 0000", b, ref_mem[8'h00]);
    chk(sda_oe == 0, "R7 released after nack", sda_oe, 0);
    i2c_stop();
    chk(addr == 16'h0001, "R8 counter after wrap", addr, 16'h0001);
    i2c_start();
    send_byte(dev_r(), k); chk(k, "R7 ack after nack+stop", k, 1);
    recv_byte(1'b0, b);
    i2c_stop();
    chk(b == ref_mem[8'h01], "R6 continue after seq", b, ref_mem[8'h01]);
  endtask

  task automatic t_busy();
    bit k;
    int s0 = n_stop;
    busy = 1'b1;
    i2c_start();
    send_byte(dev_w(), k); chk(!k, "R9 busy nack", k, 0);
    i2c_stop();
    busy = 1'b0;
    i2c_start();
    send_byte(dev_w(), k); chk(k, "R9 ack after busy", k, 1);
    i2c_stop();
    wq();
    chk(n_stop == s0, "R5 no stop strobe without data", n_stop - s0, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = init_val(i);
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    wq(2);
    t_reset();
    t_mismatch();
    t_byte_write();
    t_cur_read();
    t_page_wrap();
    t_random_read();
    t_seq_wrap();
    t_busy();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vecs++;
      errs++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule